// File: doc/BRIEF.md
# Clock Phase Sweep Calibration Controller

This controller searches for the best sampling phase of a capture clock that is produced by a phase shifter adjusted one step at a time. It owns the shifter's step pulse and direction line. After a start request it first moves the shifter from its reset position of zero down to the most negative setting. No tests are run on the way down. It then climbs back one step at a time up to the most positive setting. After every step it waits a fixed settling time. At each setting of the climb it asks an external tester for a pass/fail verdict.

Runs of consecutive passing settings form windows. The controller keeps the first two windows it closes. For each one it reports the lowest and highest passing setting and the midpoint between them. It also reports one chosen setting to program into the shifter. That is the midpoint of the first stored window whose midpoint is not negative, which is the window in the positive half of the clock cycle. A third window is not stored and raises an overflow flag. An empty search raises a fail flag.

The tester interface is a request/done handshake. The request is the valid side and done is the ready side. The request stays high and the setting stays unchanged until the tester returns done. The tester may hold done low for as many cycles as it needs, and that back-pressure stalls the sweep. Done and pass are looked at only while the request is high. Start, busy, complete and the result outputs are plain level or pulse signals.

Top module: `phsw_cal_top`

## Requirements
- R1: After reset, busy_o, complete_o, step_o, test_req_o, overflow_o and fail_o are 0, win_valid_o is all zero, and optimal_o is 0.
- R2: start_i while idle begins a sweep. busy_o is high from the next cycle until the complete_o cycle, and low after it. complete_o is a single-cycle pulse, given once per sweep. start_i while busy is ignored.
- R3: The descent gives exactly PHASE_LIMIT (255) step pulses with dir_inc_o = 0 (0 = decrement, 1 = increment), taking the setting from 0 to -255. No test request is raised until the setting is -255.
- R4: step_o is high for exactly one cycle per step. After each pulse, at least SETTLE_CYCLES idle cycles pass before the next pulse or test request.
- R5: The climb tests each setting from -255 to +255 exactly once, in ascending order, giving 511 tests. It uses 2*PHASE_LIMIT step pulses with dir_inc_o = 1. phase_o shows the setting under test.
- R6: test_req_o stays high, with phase_o stable, until test_done_i is sampled high. test_pass_i is taken in that cycle. test_done_i while test_req_o is low has no effect.
- R7: A window is a maximal run of passing settings. A window still open at +255 closes at +255. Slot 0 holds the first closed window and slot 1 the second. win_lo_o and win_hi_o give its ends as signed 9-bit values, and win_valid_o[i] marks slot i as filled.
- R8: win_mid_o is (lo + hi) / 2 with truncation toward zero. For example -21..86 gives 32, and -255..-150 gives -202.
- R9: optimal_o is the midpoint of the lowest-index stored window whose midpoint is 0 or more. If no stored window qualifies, it is the slot 0 midpoint.
- R10: A third or later window is not stored and sets overflow_o. Slots 0 and 1 keep the first two windows.
- R11: With no passing setting, fail_o is 1 and optimal_o is 0. Results are valid in the complete_o cycle.
- R12: A new start clears all results of the previous sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sweep (taken only when idle) |
| busy_o | output | 1 | Sweep in progress |
| complete_o | output | 1 | One-cycle pulse at the end of a sweep |
| step_o | output | 1 | One-cycle phase step pulse to the shifter |
| dir_inc_o | output | 1 | Step direction: 1 increment, 0 decrement |
| phase_o | output | 9 | Current signed setting |
| test_req_o | output | 1 | Test request for the current setting |
| test_done_i | input | 1 | Tester verdict ready |
| test_pass_i | input | 1 | Verdict: 1 pass, 0 fail |
| win_valid_o | output | 2 | Slot filled flags |
| win_lo_o | output | 2x9 | Signed low end per slot |
| win_hi_o | output | 2x9 | Signed high end per slot |
| win_mid_o | output | 2x9 | Signed midpoint per slot |
| overflow_o | output | 1 | More windows than slots |
| fail_o | output | 1 | No passing setting found |
| optimal_o | output | 9 | Chosen signed setting |

## Verification
The hardest case to reach is a verdict offered while no request is pending. This can happen during a settling gap, just before the request rises. If the controller took it, a phantom pass would appear. The tester model therefore holds done and pass high in every gap of an all-failing sweep, with a tester delay that varies per setting, and the result must still be a fail with no windows. Windows that are still open at +255, negative odd endpoint sums, the third-window overflow and a start issued in mid-sweep are each driven by a directed pass pattern.

// File: rtl/phsw_pkg.sv
package phsw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STEP,
    ST_WAIT,
    ST_TEST,
    ST_DONE
  } phsw_state_e;
endpackage

// File: rtl/phsw_settle_timer.sv
module phsw_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R4: a fresh load never reads as already expired unless the gap is one cycle
  assert_load_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == LOAD_VAL));
endmodule

// File: rtl/phsw_sweep_fsm.sv
module phsw_sweep_fsm
  import phsw_pkg::*;
#(
  parameter int unsigned PHASE_LIMIT = 255,
  parameter int unsigned PW = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 settled_i,
  input  logic                 test_done_i,
  input  logic                 test_pass_i,
  output logic                 busy_o,
  output logic                 complete_o,
  output logic                 step_o,
  output logic                 dir_inc_o,
  output logic signed [PW-1:0] phase_o,
  output logic                 test_req_o,
  output logic                 clear_o,
  output logic                 rec_valid_o,
  output logic                 rec_pass_o,
  output logic                 rec_last_o
);
  localparam logic signed [PW-1:0] PH_MAX = PW'(PHASE_LIMIT);
  localparam logic signed [PW-1:0] PH_MIN = -PH_MAX;

  phsw_state_e         state_q;
  logic signed [PW-1:0] phase_q;
  logic                ascend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= '0;
      ascend_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_STEP;
          phase_q  <= '0;
          ascend_q <= 1'b0;
        end
        ST_STEP: begin
          phase_q <= ascend_q ? phase_q + 1'b1 : phase_q - 1'b1;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (settled_i) begin
          if (ascend_q) state_q <= ST_TEST;
          else if (phase_q == PH_MIN) begin
            ascend_q <= 1'b1;
            state_q  <= ST_TEST;
          end else state_q <= ST_STEP;
        end
        ST_TEST: if (test_done_i) begin
          state_q <= (phase_q == PH_MAX) ? ST_DONE : ST_STEP;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign complete_o  = (state_q == ST_DONE);
  assign step_o      = (state_q == ST_STEP);
  assign test_req_o  = (state_q == ST_TEST);
  assign dir_inc_o   = ascend_q;
  assign phase_o     = phase_q;
  assign clear_o     = (state_q == ST_IDLE) && start_i;
  assign rec_valid_o = test_req_o && test_done_i;
  assign rec_pass_o  = test_pass_i;
  assign rec_last_o  = (phase_q == PH_MAX);

  assert_step_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o && !test_req_o);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req_o && !test_done_i) |=> (test_req_o && $stable(phase_o)));

  assert_no_desc_test_R3: assert property (@(posedge clk) disable iff (!rst_n)
    test_req_o |-> (dir_inc_o || phase_o == PH_MIN));

  assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o >= PH_MIN) && (phase_o <= PH_MAX));

  assert_complete_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    complete_o |=> !busy_o && !complete_o);
endmodule

// File: rtl/phsw_window_log.sv
module phsw_window_log #(
  parameter int unsigned PW = 9,
  parameter int unsigned NUM_WIN = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear_i,
  input  logic                          rec_valid_i,
  input  logic                          rec_pass_i,
  input  logic                          rec_last_i,
  input  logic signed [PW-1:0]          rec_pos_i,
  output logic [NUM_WIN-1:0]            win_valid_o,
  output logic [NUM_WIN-1:0][PW-1:0]    win_lo_o,
  output logic [NUM_WIN-1:0][PW-1:0]    win_hi_o,
  output logic [NUM_WIN-1:0][PW-1:0]    win_mid_o,
  output logic                          overflow_o,
  output logic                          fail_o,
  output logic signed [PW-1:0]          optimal_o
);
  localparam int CNTW = $clog2(NUM_WIN + 1);

  logic                       in_win_q;
  logic signed [PW-1:0]       open_lo_q;
  logic [CNTW-1:0]            count_q;
  logic                       result_q;
  logic                       overflow_q;
  logic [NUM_WIN-1:0]         valid_q;
  logic [NUM_WIN-1:0][PW-1:0] lo_q;
  logic [NUM_WIN-1:0][PW-1:0] hi_q;

  logic                 close_w;
  logic signed [PW-1:0] close_lo_w;
  logic signed [PW-1:0] close_hi_w;

  assign close_w    = rec_valid_i && ((in_win_q && !rec_pass_i) || (rec_pass_i && rec_last_i));
  assign close_lo_w = in_win_q ? open_lo_q : rec_pos_i;
  assign close_hi_w = rec_pass_i ? rec_pos_i : rec_pos_i - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_win_q   <= 1'b0;
      open_lo_q  <= '0;
      count_q    <= '0;
      result_q   <= 1'b0;
      overflow_q <= 1'b0;
      valid_q    <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
    end else if (clear_i) begin
      in_win_q   <= 1'b0;
      count_q    <= '0;
      result_q   <= 1'b0;
      overflow_q <= 1'b0;
      valid_q    <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
    end else if (rec_valid_i) begin
      in_win_q <= rec_pass_i && !rec_last_i;
      if (rec_pass_i && !in_win_q) open_lo_q <= rec_pos_i;
      if (rec_last_i) result_q <= 1'b1;
      if (close_w) begin
        if (count_q < CNTW'(NUM_WIN)) begin
          valid_q[count_q] <= 1'b1;
          lo_q[count_q]    <= close_lo_w;
          hi_q[count_q]    <= close_hi_w;
          count_q          <= count_q + 1'b1;
        end else begin
          overflow_q <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_mid
    logic signed [PW:0] sum_w;
    logic signed [PW:0] adj_w;
    assign sum_w = $signed({lo_q[g][PW-1], lo_q[g]}) + $signed({hi_q[g][PW-1], hi_q[g]});
    assign adj_w = (sum_w[PW] && sum_w[0]) ? sum_w + 1'b1 : sum_w;
    assign win_mid_o[g] = adj_w[PW:1];
  end

  always_comb begin
    logic found;
    found     = 1'b0;
    optimal_o = win_mid_o[0];
    for (int i = 0; i < NUM_WIN; i++) begin
      if (!found && valid_q[i] && !win_mid_o[i][PW-1]) begin
        optimal_o = win_mid_o[i];
        found     = 1'b1;
      end
    end
    if (!result_q || !valid_q[0]) optimal_o = '0;
  end

  assign win_valid_o = valid_q;
  assign win_lo_o    = lo_q;
  assign win_hi_o    = hi_q;
  assign overflow_o  = overflow_q;
  assign fail_o      = result_q && !valid_q[0];

  assert_ovf_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_q |-> (&valid_q));

  assert_win_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q[0] |-> ($signed(lo_q[0]) <= $signed(hi_q[0])));

  assert_fail_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (optimal_o == '0) && (win_valid_o == '0));
endmodule

// File: rtl/phsw_cal_top.sv
module phsw_cal_top #(
  parameter int unsigned PHASE_LIMIT   = 255,
  parameter int unsigned SETTLE_CYCLES = 4,
  parameter int unsigned NUM_WIN       = 2,
  parameter int unsigned PW            = $clog2(PHASE_LIMIT + 1) + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  output logic                       busy_o,
  output logic                       complete_o,
  output logic                       step_o,
  output logic                       dir_inc_o,
  output logic [PW-1:0]              phase_o,
  output logic                       test_req_o,
  input  logic                       test_done_i,
  input  logic                       test_pass_i,
  output logic [NUM_WIN-1:0]         win_valid_o,
  output logic [NUM_WIN-1:0][PW-1:0] win_lo_o,
  output logic [NUM_WIN-1:0][PW-1:0] win_hi_o,
  output logic [NUM_WIN-1:0][PW-1:0] win_mid_o,
  output logic                       overflow_o,
  output logic                       fail_o,
  output logic [PW-1:0]              optimal_o
);
  logic                 settled_w;
  logic                 clear_w;
  logic                 rec_valid_w;
  logic                 rec_pass_w;
  logic                 rec_last_w;
  logic                 step_w;
  logic signed [PW-1:0] phase_w;
  logic signed [PW-1:0] optimal_w;

  phsw_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (step_w),
    .expired_o (settled_w)
  );

  phsw_sweep_fsm #(.PHASE_LIMIT(PHASE_LIMIT), .PW(PW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .settled_i   (settled_w),
    .test_done_i (test_done_i),
    .test_pass_i (test_pass_i),
    .busy_o      (busy_o),
    .complete_o  (complete_o),
    .step_o      (step_w),
    .dir_inc_o   (dir_inc_o),
    .phase_o     (phase_w),
    .test_req_o  (test_req_o),
    .clear_o     (clear_w),
    .rec_valid_o (rec_valid_w),
    .rec_pass_o  (rec_pass_w),
    .rec_last_o  (rec_last_w)
  );

  phsw_window_log #(.PW(PW), .NUM_WIN(NUM_WIN)) u_log (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_w),
    .rec_valid_i (rec_valid_w),
    .rec_pass_i  (rec_pass_w),
    .rec_last_i  (rec_last_w),
    .rec_pos_i   (phase_w),
    .win_valid_o (win_valid_o),
    .win_lo_o    (win_lo_o),
    .win_hi_o    (win_hi_o),
    .win_mid_o   (win_mid_o),
    .overflow_o  (overflow_o),
    .fail_o      (fail_o),
    .optimal_o   (optimal_w)
  );

  assign step_o    = step_w;
  assign phase_o   = phase_w;
  assign optimal_o = optimal_w;

  assert_results_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    complete_o |-> (fail_o || win_valid_o[0]));
endmodule

// File: tb/phsw_cal_top_tb_top.sv
module phsw_cal_top_tb_top;
  localparam int LIM = 255;
  localparam int SET = 3;
  localparam int NW  = 2;
  localparam int PW  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic test_done_i = 1'b0;
  logic test_pass_i = 1'b0;
  logic busy_o, complete_o, step_o, dir_inc_o, test_req_o, overflow_o, fail_o;
  logic [PW-1:0] phase_o, optimal_o;
  logic [NW-1:0] win_valid_o;
  logic [NW-1:0][PW-1:0] win_lo_o, win_hi_o, win_mid_o;

  always #2 clk = ~clk;

  phsw_cal_top #(.PHASE_LIMIT(LIM), .SETTLE_CYCLES(SET), .NUM_WIN(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .complete_o(complete_o), .step_o(step_o), .dir_inc_o(dir_inc_o),
    .phase_o(phase_o), .test_req_o(test_req_o), .test_done_i(test_done_i),
    .test_pass_i(test_pass_i), .win_valid_o(win_valid_o), .win_lo_o(win_lo_o),
    .win_hi_o(win_hi_o), .win_mid_o(win_mid_o), .overflow_o(overflow_o),
    .fail_o(fail_o), .optimal_o(optimal_o)
  );

  int checks = 0, errors = 0;
  int r_lo[3], r_hi[3], r_n = 0;
  bit inject = 1'b0;
  bit timeout = 1'b0;

  int dec_cnt, inc_cnt, test_cnt, desc_req, gap_err, order_err, cmp_cnt;
  int since_step, exp_pos, cycles = 0;
  bit had_step, req_prev = 1'b0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit pass_at(int p);
    for (int i = 0; i < r_n; i++) if (p >= r_lo[i] && p <= r_hi[i]) return 1'b1;
    return 1'b0;
  endfunction

  // tester model, driven at the falling edge
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (test_req_o) begin
        inject = inject;
        if (lat >= ($signed(phase_o) & 3)) begin
          test_done_i <= 1'b1;
          test_pass_i <= pass_at($signed(phase_o));
          lat = 0;
        end else begin
          test_done_i <= 1'b0;
          lat++;
        end
      end else begin
        lat = 0;
        test_done_i <= inject && busy_o;
        test_pass_i <= inject && busy_o;
      end
    end
  end

  // monitor, sampled 1 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      cycles++;
      if (cycles > 190000 && !timeout) begin
        timeout = 1'b1;
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      end
      since_step++;
      if (test_req_o && !req_prev) begin
        if (had_step && since_step < SET + 1) gap_err++;
        if (dec_cnt < LIM) desc_req++;
        if ($signed(phase_o) != exp_pos) order_err++;
        exp_pos++;
        test_cnt++;
      end
      if (step_o) begin
        if (had_step && since_step < SET + 1) gap_err++;
        if (dir_inc_o) inc_cnt++; else dec_cnt++;
        had_step = 1'b1;
        since_step = 0;
      end
      if (complete_o) cmp_cnt++;
      req_prev = test_req_o;
    end
  end

  task automatic run_sweep(string nm, bit restart_mid);
    int e_lo[8], e_hi[8], e_n, e_opt, found, open, olo;
    e_n = 0; open = 0; olo = 0;
    for (int p = -LIM; p <= LIM; p++) begin
      if (pass_at(p) && !open) begin open = 1; olo = p; end
      if (open && (!pass_at(p) || p == LIM)) begin
        e_lo[e_n] = olo; e_hi[e_n] = pass_at(p) ? p : p - 1; e_n++; open = 0;
      end
    end
    found = 0; e_opt = 0;
    if (e_n > 0) e_opt = (e_lo[0] + e_hi[0]) / 2;
    for (int i = 0; i < NW && i < e_n; i++)
      if (!found && (e_lo[i] + e_hi[i]) / 2 >= 0) begin found = 1; e_opt = (e_lo[i] + e_hi[i]) / 2; end

    dec_cnt = 0; inc_cnt = 0; test_cnt = 0; desc_req = 0; gap_err = 0;
    order_err = 0; cmp_cnt = 0; exp_pos = -LIM; had_step = 1'b0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check({nm, " R2 busy after start"}, int'(busy_o), 1);
    if (restart_mid) begin
      repeat (600) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    end
    while (!complete_o && !timeout) begin @(posedge clk); #1; end
    check({nm, " R2 busy in complete cycle"}, int'(busy_o), 1);
    check({nm, " R7 slot0 valid"}, int'(win_valid_o[0]), int'(e_n > 0));
    check({nm, " R7 slot1 valid"}, int'(win_valid_o[1]), int'(e_n > 1));
    for (int i = 0; i < NW && i < e_n; i++) begin
      check($sformatf("%s R7 lo%0d", nm, i), int'($signed(win_lo_o[i])), e_lo[i]);
      check($sformatf("%s R7 hi%0d", nm, i), int'($signed(win_hi_o[i])), e_hi[i]);
      check($sformatf("%s R8 mid%0d", nm, i), int'($signed(win_mid_o[i])), (e_lo[i] + e_hi[i]) / 2);
    end
    check({nm, " R9 optimal"}, int'($signed(optimal_o)), e_opt);
    check({nm, " R10 overflow"}, int'(overflow_o), int'(e_n > NW));
    check({nm, " R11 fail"}, int'(fail_o), int'(e_n == 0));
    @(posedge clk); #1;
    check({nm, " R2 busy low after"}, int'(busy_o), 0);
    check({nm, " R2 one complete"}, cmp_cnt, 1);
    check({nm, " R3 decrement steps"}, dec_cnt, LIM);
    check({nm, " R3 no test in descent"}, desc_req, 0);
    check({nm, " R4 settle gaps"}, gap_err, 0);
    check({nm, " R5 increment steps"}, inc_cnt, 2 * LIM);
    check({nm, " R5 tests"}, test_cnt, 2 * LIM + 1);
    check({nm, " R5 R6 order"}, order_err, 0);
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy_o), 0);
    check("R1 complete", int'(complete_o), 0);
    check("R1 step", int'(step_o), 0);
    check("R1 req", int'(test_req_o), 0);
    check("R1 valid", int'(win_valid_o), 0);
    check("R1 overflow", int'(overflow_o), 0);
    check("R1 fail", int'(fail_o), 0);
    check("R1 optimal", int'(optimal_o), 0);
  endtask

  task automatic t_single();   // one window, mid-sweep start ignored (R2)
    r_n = 1; r_lo[0] = -21; r_hi[0] = 86; inject = 1'b0;
    run_sweep("single", 1'b1);
  endtask

  task automatic t_two_open(); // odd negative sum and window open at +255
    r_n = 2; r_lo[0] = -255; r_hi[0] = -150; r_lo[1] = 100; r_hi[1] = 255;
    run_sweep("two_open", 1'b0);
  endtask

  task automatic t_three();    // R10 overflow
    r_n = 3; r_lo[0] = -200; r_hi[0] = -190; r_lo[1] = -10; r_hi[1] = 20;
    r_lo[2] = 50; r_hi[2] = 60;
    run_sweep("three", 1'b0);
  endtask

  task automatic t_neg_only(); // R9 fallback to slot 0
    r_n = 1; r_lo[0] = -100; r_hi[0] = -50;
    run_sweep("neg_only", 1'b0);
  endtask

  task automatic t_none();     // R11 and R12 clear, R6 stray done ignored
    r_n = 0; inject = 1'b1;
    run_sweep("none_R12", 1'b0);
    inject = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single();
    t_two_open();
    t_three();
    t_neg_only();
    t_none();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule